// File: doc/BRIEF.md
# Saved context readout unit

This block sits beside a block-cipher engine and keeps what a finished operation leaves behind: the 128-bit chaining or counter value and the 128-bit authentication tag. When the engine reports completion of an operation that asked for its context to be kept, both values are captured and a ready flag goes high. Software then reads the values one 32-bit word at a time through a simple read port, and can poll the flag through a status selection on the same port.

The ready flag doubles as an interlock. While it is high the engine is refused permission to begin its next operation, and the flag drops only when software reads the highest word of either captured value. Software that needs only the final word may read it alone. A separate compare path checks a software-supplied expected tag against the captured tag over a programmable number of leading bytes and reports pass or fail.

The cipher datapath, the DMA and the bus fabric are outside the block; completion, the save request and the result values arrive as plain inputs.

Top module: `ctxr_readout`

## Requirements
- R1: After reset the ready flag is low, no read or compare result is flagged valid, and both captured values read as zero.
- R2: A completion pulse with the save request high captures the chaining value and the tag and raises the ready flag on the following cycle.
- R3: A completion pulse with the save request low changes neither the captured values nor the ready flag.
- R4: A read request returns, one cycle later with the valid flag high, word n of the selected value (select 0 chaining value, 1 tag), word n being bits [32n+31:32n].
- R5: Reads of words 0, 1 and 2 leave the ready flag unchanged.
- R6: A read of word 3 of either the chaining value or the tag clears the ready flag, also when no lower word was read before it.
- R7: Select 2 returns a status word holding the ready flag in bit 0 and zeros elsewhere; select 3 returns zero; neither changes the ready flag.
- R8: The start grant equals the start request while the ready flag is low and is held low while it is high.
- R9: A completion with save while the flag is already high overwrites both captured values and keeps the flag high, including when it coincides with a word 3 read.
- R10: A compare request produces, one cycle later, a valid pulse with exactly one of pass or fail; byte k of a tag is bits [8k+7:8k], and pass means the first L bytes of the expected and captured tags match.
- R11: Compare lengths above 16 act as 16, and a length of 0 compares nothing and passes.
- R12: A compare request has no effect on the ready flag or the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_done_i | input | 1 | Completion pulse from the cipher engine |
| op_save_i | input | 1 | Save request of the finished operation |
| op_iv_i | input | 128 | Chaining or counter value at completion |
| op_tag_i | input | 128 | Authentication tag at completion |
| start_req_i | input | 1 | Engine asks to begin a new operation |
| start_grant_o | output | 1 | Permission to begin (combinational) |
| ctx_ready_o | output | 1 | Captured context waiting to be read |
| rd_en_i | input | 1 | Read request |
| rd_sel_i | input | 2 | 0 chaining value, 1 tag, 2 status, 3 none |
| rd_word_i | input | 2 | Word index within the selected value |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| cmp_start_i | input | 1 | Compare request |
| cmp_len_i | input | 5 | Number of leading bytes to compare |
| cmp_tag_i | input | 128 | Expected tag |
| cmp_valid_o | output | 1 | Compare result valid |
| cmp_pass_o | output | 1 | Tags match over the requested length |
| cmp_fail_o | output | 1 | Tags differ over the requested length |

## Verification
The bench aims at the flag's edges: a lone word 3 read with no lower words before it (a design counting four reads would never release the engine), a completion that lands in the same cycle as that read (a design giving the clear priority would lose a fresh context), and lower-word and status reads that must not drop the flag early. On the compare side it plants a single wrong byte just outside and just inside the requested length and uses lengths 0 and above 16, which catch an off-by-one mask, a reversed byte order or an unclamped length. A behavioural reference model runs beside the design over directed and random traffic, so any deviation on any output in any cycle is reported.

// File: rtl/ctxr_pkg.sv
package ctxr_pkg;

  typedef enum logic [1:0] {
    SEL_IV   = 2'd0,
    SEL_TAG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

endpackage

// File: rtl/ctxr_store.sv
module ctxr_store #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      done_i,
  input  logic                      save_i,
  input  logic [WORD_W*N_WORDS-1:0] iv_i,
  input  logic [WORD_W*N_WORDS-1:0] tag_i,
  input  logic                      clr_i,
  output logic [WORD_W*N_WORDS-1:0] iv_q,
  output logic [WORD_W*N_WORDS-1:0] tag_q,
  output logic                      ready_q
);

  localparam int CTX_W = WORD_W * N_WORDS;

  logic             ld_en;
  logic             ready_d;
  logic [CTX_W-1:0] iv_d;
  logic [CTX_W-1:0] tag_d;

  // next state: a capture outranks the clear from a final-word read
  always_comb begin
    ld_en   = done_i & save_i;
    iv_d    = iv_i;
    tag_d   = tag_i;
    ready_d = ready_q;
    if (ld_en) begin
      ready_d = 1'b1;
    end else if (clr_i) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q  <= '0;
      tag_q <= '0;
    end else if (ld_en) begin
      iv_q  <= iv_d;
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
    end
  end

endmodule

// File: rtl/ctxr_rdport.sv
module ctxr_rdport
  import ctxr_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en_i,
  input  rd_sel_e                    rd_sel_i,
  input  logic [$clog2(N_WORDS)-1:0] rd_word_i,
  input  logic [WORD_W*N_WORDS-1:0]  iv_q,
  input  logic [WORD_W*N_WORDS-1:0]  tag_q,
  input  logic                       ready_q,
  output logic                       last_hit_o,
  output logic                       rd_valid_o,
  output logic [WORD_W-1:0]          rd_data_o
);

  localparam int IDX_W = $clog2(N_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  logic [WORD_W-1:0] iv_w  [N_WORDS];
  logic [WORD_W-1:0] tag_w [N_WORDS];
  logic [WORD_W-1:0] data_d;
  logic              data_en;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_slice
    assign iv_w[g]  = iv_q[g*WORD_W +: WORD_W];
    assign tag_w[g] = tag_q[g*WORD_W +: WORD_W];
  end

  always_comb begin
    unique case (rd_sel_i)
      SEL_IV:   data_d = iv_w[rd_word_i];
      SEL_TAG:  data_d = tag_w[rd_word_i];
      SEL_STAT: data_d = {{(WORD_W-1){1'b0}}, ready_q};
      default:  data_d = '0;
    endcase
    data_en    = rd_en_i;
    last_hit_o = rd_en_i && (rd_sel_i == SEL_IV || rd_sel_i == SEL_TAG)
                 && (rd_word_i == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o <= '0;
    end else if (data_en) begin
      rd_data_o <= data_d;
    end
  end

endmodule

// File: rtl/ctxr_tagcmp.sv
module ctxr_tagcmp #(
  parameter int CTX_W = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [$clog2(CTX_W/8):0]      len_i,
  input  logic [CTX_W-1:0]              exp_tag_i,
  input  logic [CTX_W-1:0]              tag_q,
  output logic                          valid_o,
  output logic                          pass_o
);

  localparam int N_BYTES = CTX_W / 8;
  localparam int LEN_W   = $clog2(N_BYTES) + 1;
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(N_BYTES);

  logic [LEN_W-1:0]   eff_len;
  logic [N_BYTES-1:0] byte_bad;
  logic               pass_d;

  assign eff_len = (len_i > MAX_LEN) ? MAX_LEN : len_i;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    assign byte_bad[k] = (LEN_W'(k) < eff_len) &&
                         (exp_tag_i[8*k +: 8] != tag_q[8*k +: 8]);
  end

  assign pass_d = ~|byte_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= start_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_o <= 1'b0;
    end else if (start_i) begin
      pass_o <= pass_d;
    end
  end

endmodule

// File: rtl/ctxr_readout.sv
module ctxr_readout
  import ctxr_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  op_done_i,
  input  logic                                  op_save_i,
  input  logic [WORD_W*N_WORDS-1:0]             op_iv_i,
  input  logic [WORD_W*N_WORDS-1:0]             op_tag_i,
  input  logic                                  start_req_i,
  output logic                                  start_grant_o,
  output logic                                  ctx_ready_o,
  input  logic                                  rd_en_i,
  input  logic [1:0]                            rd_sel_i,
  input  logic [$clog2(N_WORDS)-1:0]            rd_word_i,
  output logic                                  rd_valid_o,
  output logic [WORD_W-1:0]                     rd_data_o,
  input  logic                                  cmp_start_i,
  input  logic [$clog2(WORD_W*N_WORDS/8):0]     cmp_len_i,
  input  logic [WORD_W*N_WORDS-1:0]             cmp_tag_i,
  output logic                                  cmp_valid_o,
  output logic                                  cmp_pass_o,
  output logic                                  cmp_fail_o
);

  localparam int CTX_W = WORD_W * N_WORDS;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [CTX_W-1:0] iv_q;
  logic [CTX_W-1:0] tag_q;
  logic             ready_q;
  logic             last_hit;
  logic             cmp_pass_q;
  rd_sel_e          sel;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  assign sel = rd_sel_e'(rd_sel_i);

  ctxr_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .done_i  (op_done_i),
    .save_i  (op_save_i),
    .iv_i    (op_iv_i),
    .tag_i   (op_tag_i),
    .clr_i   (last_hit),
    .iv_q    (iv_q),
    .tag_q   (tag_q),
    .ready_q (ready_q)
  );

  ctxr_rdport #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_rdport (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (sel),
    .rd_word_i  (rd_word_i),
    .iv_q       (iv_q),
    .tag_q      (tag_q),
    .ready_q    (ready_q),
    .last_hit_o (last_hit),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  ctxr_tagcmp #(.CTX_W(CTX_W)) u_tagcmp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (cmp_start_i),
    .len_i     (cmp_len_i),
    .exp_tag_i (cmp_tag_i),
    .tag_q     (tag_q),
    .valid_o   (cmp_valid_o),
    .pass_o    (cmp_pass_q)
  );

  assign ctx_ready_o   = ready_q;
  assign start_grant_o = start_req_i & ~ready_q;
  assign cmp_pass_o    = cmp_valid_o & cmp_pass_q;
  assign cmp_fail_o    = cmp_valid_o & ~cmp_pass_q;

endmodule

// File: rtl/ctxr_readout_chk.sv
module ctxr_readout_chk #(
  parameter int N_WORDS = 4
) (
  input logic                       clk,
  input logic                       rst_int_n,
  input logic                       op_done_i,
  input logic                       op_save_i,
  input logic                       start_req_i,
  input logic                       start_grant_o,
  input logic                       ctx_ready_o,
  input logic                       rd_en_i,
  input logic [1:0]                 rd_sel_i,
  input logic [$clog2(N_WORDS)-1:0] rd_word_i,
  input logic                       rd_valid_o,
  input logic                       cmp_start_i,
  input logic                       cmp_valid_o,
  input logic                       cmp_pass_o,
  input logic                       cmp_fail_o
);

  localparam int IDX_W = $clog2(N_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  // R2
  save_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_done_i && op_save_i) |=> ctx_ready_o);

  // R3
  nosave_keeps_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctx_ready_o && !(op_done_i && op_save_i)) |=> !ctx_ready_o);

  // R5
  low_read_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctx_ready_o && !(rd_en_i && rd_sel_i[1] == 1'b0 && rd_word_i == LAST_IDX))
    |=> ctx_ready_o);

  // R6
  last_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en_i && rd_sel_i[1] == 1'b0 && rd_word_i == LAST_IDX && !(op_done_i && op_save_i))
    |=> !ctx_ready_o);

  // R4
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_en_i |=> rd_valid_o);

  // R8
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctx_ready_o |-> !start_grant_o);

  // R8
  start_passes_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctx_ready_o && start_req_i) |-> start_grant_o);

  // R10
  cmp_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmp_start_i |=> cmp_valid_o);

  // R10
  cmp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmp_valid_o |-> (cmp_pass_o != cmp_fail_o));

  // R10
  cmp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cmp_valid_o |-> (!cmp_pass_o && !cmp_fail_o));

endmodule

bind ctxr_readout ctxr_readout_chk #(.N_WORDS(N_WORDS)) u_chk (
  .clk           (clk),
  .rst_int_n     (rst_int_n),
  .op_done_i     (op_done_i),
  .op_save_i     (op_save_i),
  .start_req_i   (start_req_i),
  .start_grant_o (start_grant_o),
  .ctx_ready_o   (ctx_ready_o),
  .rd_en_i       (rd_en_i),
  .rd_sel_i      (rd_sel_i),
  .rd_word_i     (rd_word_i),
  .rd_valid_o    (rd_valid_o),
  .cmp_start_i   (cmp_start_i),
  .cmp_valid_o   (cmp_valid_o),
  .cmp_pass_o    (cmp_pass_o),
  .cmp_fail_o    (cmp_fail_o)
);

// File: tb/tb_ctxr_readout.sv
`timescale 1ns/1ps
module tb_ctxr_readout;

  logic         clk;
  logic         rst_n;
  logic         op_done_i, op_save_i;
  logic [127:0] op_iv_i, op_tag_i;
  logic         start_req_i;
  logic         start_grant_o, ctx_ready_o;
  logic         rd_en_i;
  logic [1:0]   rd_sel_i, rd_word_i;
  logic         rd_valid_o;
  logic [31:0]  rd_data_o;
  logic         cmp_start_i;
  logic [4:0]   cmp_len_i;
  logic [127:0] cmp_tag_i;
  logic         cmp_valid_o, cmp_pass_o, cmp_fail_o;

  int checks = 0;
  int fails  = 0;
  bit checking = 0;
  bit finished = 0;

  ctxr_readout dut (
    .clk(clk), .rst_n(rst_n),
    .op_done_i(op_done_i), .op_save_i(op_save_i),
    .op_iv_i(op_iv_i), .op_tag_i(op_tag_i),
    .start_req_i(start_req_i), .start_grant_o(start_grant_o),
    .ctx_ready_o(ctx_ready_o),
    .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .rd_word_i(rd_word_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .cmp_start_i(cmp_start_i), .cmp_len_i(cmp_len_i), .cmp_tag_i(cmp_tag_i),
    .cmp_valid_o(cmp_valid_o), .cmp_pass_o(cmp_pass_o), .cmp_fail_o(cmp_fail_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference model
  logic [127:0] m_iv, m_tag;
  logic         m_ready, m_rdv, m_cv, m_cp;
  logic [31:0]  m_rdd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_iv <= '0; m_tag <= '0; m_ready <= 0;
      m_rdv <= 0; m_rdd <= '0; m_cv <= 0; m_cp <= 0;
    end else begin
      logic nr;
      int n;
      logic ok;
      nr = m_ready;
      if (rd_en_i && rd_sel_i < 2 && rd_word_i == 3) nr = 0;
      if (op_done_i && op_save_i) begin
        nr = 1;
        m_iv  <= op_iv_i;
        m_tag <= op_tag_i;
      end
      m_ready <= nr;
      m_rdv <= rd_en_i;
      if (rd_en_i) begin
        case (rd_sel_i)
          2'd0: m_rdd <= m_iv[32*rd_word_i +: 32];
          2'd1: m_rdd <= m_tag[32*rd_word_i +: 32];
          2'd2: m_rdd <= {31'd0, m_ready};
          default: m_rdd <= 32'd0;
        endcase
      end
      m_cv <= cmp_start_i;
      if (cmp_start_i) begin
        n = (cmp_len_i > 16) ? 16 : int'(cmp_len_i);
        ok = 1;
        for (int k = 0; k < n; k++)
          if (m_tag[8*k +: 8] != cmp_tag_i[8*k +: 8]) ok = 0;
        m_cp <= ok;
      end
    end
  end

  task automatic check(input bit good, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after the falling edge
  always @(negedge clk) begin
    #2;
    if (checking && !finished) begin
      check(ctx_ready_o === m_ready, "R2 R3 R5 R6 R7 R9 R12", "ctx_ready",
            {31'd0, ctx_ready_o}, {31'd0, m_ready});
      check(start_grant_o === (start_req_i & ~m_ready), "R8", "start_grant",
            {31'd0, start_grant_o}, {31'd0, start_req_i & ~m_ready});
      check(rd_valid_o === m_rdv, "R4", "rd_valid", {31'd0, rd_valid_o}, {31'd0, m_rdv});
      if (m_rdv)
        check(rd_data_o === m_rdd, "R4 R7", "rd_data", rd_data_o, m_rdd);
      check(cmp_valid_o === m_cv, "R10", "cmp_valid", {31'd0, cmp_valid_o}, {31'd0, m_cv});
      if (m_cv)
        check(cmp_pass_o === m_cp && cmp_fail_o === !m_cp, "R10 R11", "cmp_pass",
              {31'd0, cmp_pass_o}, {31'd0, m_cp});
    end
  end

  task automatic idle();
    op_done_i = 0; op_save_i = 0; start_req_i = 0;
    rd_en_i = 0; rd_sel_i = 0; rd_word_i = 0;
    cmp_start_i = 0; cmp_len_i = 0;
  endtask

  task automatic op(input bit save, input logic [127:0] iv, input logic [127:0] tag);
    @(negedge clk);
    op_done_i = 1; op_save_i = save; op_iv_i = iv; op_tag_i = tag;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] w);
    @(negedge clk);
    rd_en_i = 1; rd_sel_i = sel; rd_word_i = w;
    @(negedge clk);
    idle();
  endtask

  task automatic cmp(input logic [4:0] len, input logic [127:0] t);
    @(negedge clk);
    cmp_start_i = 1; cmp_len_i = len; cmp_tag_i = t;
    @(negedge clk);
    idle();
  endtask

  function automatic logic [127:0] pattern(input logic [7:0] base);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = base + 8'(k);
    return v;
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [127:0] t0, bad;
    rst_n = 0;
    op_iv_i = '0; op_tag_i = '0; cmp_tag_i = '0;
    idle();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    #2;
    check(ctx_ready_o === 0 && rd_valid_o === 0 && cmp_valid_o === 0, "R1",
          "reset outputs", {29'd0, ctx_ready_o, rd_valid_o, cmp_valid_o}, 32'd0);
    checking = 1;
    rd(2'd0, 2'd0);        // R1: cleared chaining value reads zero
    rd(2'd1, 2'd3);        // R1 tag word 3 after reset
    // R3: completion without save
    op(0, pattern(8'h10), pattern(8'h20));
    rd(2'd2, 2'd0);
    rd(2'd0, 2'd1);
    // R2: completion with save, then R5 low reads, R7 status polls, R6 final read
    t0 = pattern(8'hA0);
    op(1, pattern(8'h30), t0);
    start_req_i = 1;       // R8 held off
    rd(2'd0, 2'd0); rd(2'd0, 2'd1); rd(2'd0, 2'd2);
    rd(2'd2, 2'd0); rd(2'd3, 2'd3);
    start_req_i = 1;
    rd(2'd0, 2'd3);
    rd(2'd2, 2'd0);
    @(negedge clk); start_req_i = 1; @(negedge clk); idle();
    // R6: tag word 3 alone releases
    op(1, pattern(8'h40), pattern(8'h50));
    rd(2'd1, 2'd3);
    rd(2'd1, 2'd0);
    // R9: overwrite while ready, then capture coinciding with word 3 read
    op(1, pattern(8'h60), t0);
    op(1, pattern(8'h70), t0);
    rd(2'd0, 2'd2);
    @(negedge clk);
    op_done_i = 1; op_save_i = 1; op_iv_i = pattern(8'h80); op_tag_i = t0;
    rd_en_i = 1; rd_sel_i = 2'd0; rd_word_i = 2'd3;
    @(negedge clk); idle();
    rd(2'd0, 2'd0);
    // R10 R11 R12: compares while ready
    bad = t0; bad[8*5 +: 8] = ~bad[8*5 +: 8];
    cmp(5'd16, t0);
    cmp(5'd5, bad);
    cmp(5'd6, bad);
    cmp(5'd1, t0);
    cmp(5'd0, ~t0);
    cmp(5'd20, t0);
    bad = t0; bad[127:120] = ~bad[127:120];
    cmp(5'd20, bad);
    cmp(5'd15, bad);
    rd(2'd1, 2'd3);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      op_done_i   = ($urandom % 6) == 0;
      op_save_i   = ($urandom % 3) != 0;
      op_iv_i     = {$urandom, $urandom, $urandom, $urandom};
      op_tag_i    = ($urandom % 2) ? t0 : {$urandom, $urandom, $urandom, $urandom};
      start_req_i = $urandom;
      rd_en_i     = ($urandom % 3) == 0;
      rd_sel_i    = 2'($urandom);
      rd_word_i   = 2'($urandom);
      cmp_start_i = ($urandom % 4) == 0;
      cmp_len_i   = 5'($urandom);
      cmp_tag_i   = ($urandom % 2) ? t0 : {$urandom, $urandom, $urandom, $urandom};
    end
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    #3;
    finish_run();
  end

endmodule